// File: doc/BRIEF.md
# Reconfigurable Cipher Primitive Execution Unit

This block is a single 32-bit execution lane for a parallel cryptographic datapath. Per issued instruction it applies one primitive from a fixed menu to three 32-bit operands: A and B come from the general register file and K from the key register file. The menu covers byte-lane table substitution, add/subtract modulo 2^32, two multiply flavours, 32-bit shifts and rotates, byte-lane Galois-field multiplication, and two- and three-input bitwise logic. The result is registered one cycle after the issue strobe, and a valid flag marks that cycle.

Two per-instruction bits fold an extra XOR with K into the same cycle. A pre-XOR replaces A with A^K before the operation. A post-XOR replaces the result R with R^K. Neither costs a cycle. The substitution tables and the field reduction polynomial change rarely, so they are loaded through a separate configuration write port rather than carried in each instruction.

Top module: `crypto_fu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first issue, `res` is 0 and `res_valid` is 0. The reduction polynomial resets to 8'h1B.
- R2: Latency is one cycle:
  - An `issue` sampled high at a rising edge makes `res_valid` high for the following cycle, and `res` carries that instruction's result.
  - Without `issue`, `res_valid` is low and `res` keeps its value.
- R3: With `pre_xor`=1 the operation uses A^K in place of A. With `post_xor`=1 the registered result is the operation result XOR K. Both bits are independent and leave the latency at one cycle.
- R4: `op`=0 performs substitution through four separate 256x8 tables, one per byte lane: lane n of the result is table n indexed by byte n of A. A table write (`cfg_we`=1, `cfg_poly`=0) stores `cfg_data` into table `cfg_addr[9:8]` at index `cfg_addr[7:0]`.
- R5: `op`=1 adds (`mode[0]`=0: A+B) or subtracts (`mode[0]`=1: A-B) modulo 2^32.
- R6: `op`=2 with `mode[0]`=0 returns the low 32 bits of A*B.
- R7: `op`=2 with `mode[0]`=1 multiplies the low 16 bits of A and B modulo 65537:
  - A zero input stands for 65536, and a product of 65536 is returned as 0.
  - The result is zero-extended to 32 bits.
  - The upper 16 bits of A and B have no effect.
- R8: `op`=3 shifts A by `B[4:0]` positions: `mode` 0 logical left, 1 logical right, 2 rotate left, 3 rotate right. `B[31:5]` have no effect.
- R9: `op`=4 multiplies each byte lane of A by the same lane of B in GF(2^8), reducing by x^8 plus the 8-bit polynomial. A write with `cfg_we`=1 and `cfg_poly`=1 loads that polynomial from `cfg_data`.
- R10: `op`=5 is two-input logic on A and B: `mode` 0 AND, 1 OR, 2 XOR, 3 NOT A.
- R11: `op`=6 is three-input logic on A, B and K: `mode` 0 AND, 1 OR, 2 XOR, 3 select `(A&B)|(~A&K)`.
- R12: Op codes 7 to 15 give an operation result of 0, to which the post-XOR still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction strobe |
| op | input | 4 | Operation class |
| mode | input | 2 | Variant within the class |
| pre_xor | input | 1 | Fold K into A before the operation |
| post_xor | input | 1 | Fold K into the result |
| opa | input | 32 | Operand A (general register) |
| opb | input | 32 | Operand B (general register) |
| opk | input | 32 | Operand K (key register) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_poly | input | 1 | 1: write polynomial, 0: write table entry |
| cfg_addr | input | 10 | Table select [9:8] and index [7:0] |
| cfg_data | input | 8 | Configuration data |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after issue |

## Verification
The bench writes each substitution table with a distinct value at the same index. A design that shares one table, or swaps lanes, then returns repeated or reordered bytes. The modulo-65537 multiply is driven with zero operands, where a design that forgets the 65536 encoding returns 0 instead of 1 or 0xFFFF. It also gets a product of exactly 65536, which must come back as 0. Shift amounts carry set bits above bit 4, and a shifter that reads them moves A too far. The reduction polynomial is changed mid-run and a byte that overflows is re-multiplied, so a hardwired polynomial shows up. Pre- and post-XOR are tried alone and together, and a design that applies K on the wrong side of the operation gives a different word.

// File: rtl/crypto_fu.sv
module crypto_fu #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [3:0]    op,
  input  logic [1:0]    mode,
  input  logic          pre_xor,
  input  logic          post_xor,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  opk,
  input  logic          cfg_we,
  input  logic          cfg_poly,
  input  logic [9:0]    cfg_addr,
  input  logic [BW-1:0] cfg_data,
  output logic [W-1:0]  res,
  output logic          res_valid
);
  localparam int LANES = W / BW;
  localparam int SHW   = $clog2(W);
  localparam int HW    = W / 2;

  localparam logic [3:0] OP_SBOX = 4'd0, OP_ADD = 4'd1, OP_MUL = 4'd2, OP_SHF = 4'd3,
                         OP_GF   = 4'd4, OP_LG2 = 4'd5, OP_LG3 = 4'd6;

  logic [BW-1:0] sbox_mem [LANES][256];
  logic [BW-1:0] poly;

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_poly) sbox_mem[cfg_addr[9:8]][cfg_addr[7:0]] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poly <= 8'h1B;
    else if (cfg_we && cfg_poly) poly <= cfg_data;
  end

  function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a, input logic [BW-1:0] b,
                                           input logic [BW-1:0] p);
    logic [BW-1:0] acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < BW; i++) begin
      if (b[i]) acc = acc ^ t;
      t = t[BW-1] ? ((t << 1) ^ p) : (t << 1);
    end
    return acc;
  endfunction

  wire [W-1:0] x = pre_xor ? (opa ^ opk) : opa;
  wire [SHW-1:0] amt = opb[SHW-1:0];

  logic [W-1:0] sbox_r, gf_r;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sbox_r[g*BW +: BW] = sbox_mem[g][x[g*BW +: BW]];
    assign gf_r[g*BW +: BW]   = gf_mul(x[g*BW +: BW], opb[g*BW +: BW], poly);
  end

  wire [W-1:0]   addsub = mode[0] ? (x - opb) : (x + opb);
  wire [2*W-1:0] prod   = x * opb;

  wire [HW:0]     ma = (x[HW-1:0] == '0)   ? {1'b1, {HW{1'b0}}} : {1'b0, x[HW-1:0]};
  wire [HW:0]     mb = (opb[HW-1:0] == '0) ? {1'b1, {HW{1'b0}}} : {1'b0, opb[HW-1:0]};
  wire [2*HW+1:0] mp = ma * mb;
  wire [2*HW+1:0] mm = mp % (2*HW+2)'(65537);
  wire [HW-1:0]   mmod = mm[HW] ? '0 : mm[HW-1:0];

  wire [2*W-1:0] dbl = {x, x};
  wire [2*W-1:0] rotl_w = dbl << amt;
  wire [2*W-1:0] rotr_w = dbl >> amt;

  logic [W-1:0] shf_r, lg2_r, lg3_r, op_r;

  always_comb begin
    unique case (mode)
      2'd0: shf_r = x << amt;
      2'd1: shf_r = x >> amt;
      2'd2: shf_r = rotl_w[2*W-1:W];
      default: shf_r = rotr_w[W-1:0];
    endcase
  end

  always_comb begin
    unique case (mode)
      2'd0: lg2_r = x & opb;
      2'd1: lg2_r = x | opb;
      2'd2: lg2_r = x ^ opb;
      default: lg2_r = ~x;
    endcase
  end

  always_comb begin
    unique case (mode)
      2'd0: lg3_r = x & opb & opk;
      2'd1: lg3_r = x | opb | opk;
      2'd2: lg3_r = x ^ opb ^ opk;
      default: lg3_r = (x & opb) | (~x & opk);
    endcase
  end

  always_comb begin
    case (op)
      OP_SBOX: op_r = sbox_r;
      OP_ADD:  op_r = addsub;
      OP_MUL:  op_r = mode[0] ? {{HW{1'b0}}, mmod} : prod[W-1:0];
      OP_SHF:  op_r = shf_r;
      OP_GF:   op_r = gf_r;
      OP_LG2:  op_r = lg2_r;
      OP_LG3:  op_r = lg3_r;
      default: op_r = '0;
    endcase
  end

  wire [W-1:0] final_r = post_xor ? (op_r ^ opk) : op_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= issue;
      if (issue) res <= final_r;
    end
  end

  AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_valid);  // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !res_valid);  // R2
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(res));  // R2
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_SHF && opb[SHW-1:0] == '0 && !pre_xor && !post_xor) |=> res == $past(opa));  // R8
  AST_XOR_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_LG2 && mode == 2'd2 && pre_xor && !post_xor) |=> res == $past(opa ^ opb ^ opk));  // R3
  AST_POLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_poly) |=> $stable(poly));  // R9
  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op > OP_LG3 && !post_xor) |=> res == '0);  // R12
endmodule

// File: tb/crypto_fu_bench.sv
module crypto_fu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  mode = '0;
  logic        pre_xor = 1'b0, post_xor = 1'b0;
  logic [31:0] opa = '0, opb = '0, opk = '0;
  logic        cfg_we = 1'b0, cfg_poly = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [31:0] res;
  logic        res_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crypto_fu u_crypto_fu (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .mode(mode),
    .pre_xor(pre_xor), .post_xor(post_xor), .opa(opa), .opb(opb), .opk(opk),
    .cfg_we(cfg_we), .cfg_poly(cfg_poly), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .res(res), .res_valid(res_valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] m, input logic pr, input logic po,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] k,
                     input string req, input logic [31:0] exp);
    @(negedge clk);
    op = o; mode = m; pre_xor = pr; post_xor = po; opa = a; opb = b; opk = k; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk(req, res, exp);
    chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
  endtask

  task automatic cfg_write(input logic poly_sel, input logic [9:0] addr, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_poly = poly_sel; cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2 + 1);
    chk("R1 res in reset", res, 32'h0);
    chk("R1 valid in reset", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res after reset", res, 32'h0);
    chk("R1 valid after reset", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_hold;
    run(4'd1, 2'd0, 1'b0, 1'b0, 32'd100, 32'd23, 32'd0, "R2 add", 32'd123);
    opa = 32'hDEAD_BEEF; opb = 32'h1; op = 4'd5;
    @(negedge clk);
    chk("R2 valid drops", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R2 res held", res, 32'd123);
  endtask

  task automatic t_addsub;
    run(4'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd2, 32'd0, "R5 add wrap", 32'd1);
    run(4'd1, 2'd1, 1'b0, 1'b0, 32'd1, 32'd2, 32'd0, "R5 sub wrap", 32'hFFFF_FFFF);
  endtask

  task automatic t_mul;
    run(4'd2, 2'd0, 1'b0, 1'b0, 32'd7, 32'd6, 32'd0, "R6 mul small", 32'd42);
    run(4'd2, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R6 mul low", 32'd1);
    run(4'd2, 2'd0, 1'b0, 1'b0, 32'h0001_0000, 32'h0001_0001, 32'd0, "R6 mul trunc", 32'h0001_0000);
    run(4'd2, 2'd1, 1'b0, 1'b0, 32'hABCD_0000, 32'h0000_0000, 32'd0, "R7 zero*zero", 32'd1);
    run(4'd2, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 32'h1234_0002, 32'd0, "R7 zero*2", 32'h0000_FFFF);
    run(4'd2, 2'd1, 1'b0, 1'b0, 32'hFFFF_0003, 32'h0000_0005, 32'd0, "R7 3*5 upper ignored", 32'd15);
    run(4'd2, 2'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_0002, 32'd0, "R7 product 65536", 32'd0);
  endtask

  task automatic t_shift;
    run(4'd3, 2'd0, 1'b0, 1'b0, 32'h8000_0001, 32'hFFFF_FFE1, 32'd0, "R8 sll", 32'h0000_0002);
    run(4'd3, 2'd1, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_0021, 32'd0, "R8 srl", 32'h4000_0000);
    run(4'd3, 2'd2, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_0021, 32'd0, "R8 rol", 32'h0000_0003);
    run(4'd3, 2'd3, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_0021, 32'd0, "R8 ror", 32'hC000_0000);
    run(4'd3, 2'd2, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0020, 32'd0, "R8 rol by 0", 32'h1234_5678);
  endtask

  task automatic t_gf;
    run(4'd4, 2'd0, 1'b0, 1'b0, 32'h5702_8001, 32'h8303_0201, 32'd0, "R9 gf default poly", 32'hC106_1B01);
    cfg_write(1'b1, 10'd0, 8'h1D);
    run(4'd4, 2'd0, 1'b0, 1'b0, 32'h0002_8001, 32'h0003_0201, 32'd0, "R9 gf new poly", 32'h0006_1D01);
  endtask

  task automatic t_logic;
    run(4'd5, 2'd0, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'd0, "R10 and", 32'hF000_000F);
    run(4'd5, 2'd1, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'd0, "R10 or", 32'hFFF0_0FFF);
    run(4'd5, 2'd2, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'd0, "R10 xor", 32'h0FF0_0FF0);
    run(4'd5, 2'd3, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'd0, "R10 not", 32'h0F0F_FF00);
    run(4'd6, 2'd0, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'h3333_3333, "R11 and3", 32'h3000_0003);
    run(4'd6, 2'd1, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'h3333_3333, "R11 or3", 32'hFFF3_3FFF);
    run(4'd6, 2'd2, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'h3333_3333, "R11 xor3", 32'h3CC3_3CC3);
    run(4'd6, 2'd3, 1'b0, 1'b0, 32'hF0F0_00FF, 32'hFF00_0F0F, 32'h3333_3333, "R11 select", 32'hF303_330F);
  endtask

  task automatic t_fold;
    run(4'd5, 2'd0, 1'b1, 1'b0, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R3 pre only", 32'hF0F0_0F0F);
    run(4'd5, 2'd0, 1'b0, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R3 post only", 32'hF0F0_0F0F);
    run(4'd5, 2'd0, 1'b1, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R3 pre and post", 32'hFFFF_0000);
    run(4'd1, 2'd0, 1'b1, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0003, "R3 pre into add", 32'h0000_0003);
  endtask

  task automatic t_sbox;
    cfg_write(1'b0, {2'd0, 8'h12}, 8'hA1);
    cfg_write(1'b0, {2'd1, 8'h34}, 8'hB2);
    cfg_write(1'b0, {2'd2, 8'h56}, 8'hC3);
    cfg_write(1'b0, {2'd3, 8'h78}, 8'hD4);
    for (int l = 0; l < 4; l++) cfg_write(1'b0, {l[1:0], 8'h00}, 8'(8'h11 * (l + 1)));
    run(4'd0, 2'd0, 1'b0, 1'b0, 32'h7856_3412, 32'd0, 32'd0, "R4 sbox lanes", 32'hD4C3_B2A1);
    run(4'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'd0, 32'd0, "R4 sbox same index", 32'h4433_2211);
    run(4'd0, 2'd0, 1'b1, 1'b1, 32'h7856_3412, 32'd0, 32'h7856_3412, "R3 R4 sbox pre post", 32'h3C65_1603);
  endtask

  task automatic t_undef;
    run(4'd7, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R12 undefined op", 32'h0);
    run(4'd15, 2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h1, 32'h0000_1234, "R12 undefined with post", 32'h0000_1234);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_addsub();
    t_mul();
    t_shift();
    t_gf();
    t_logic();
    t_fold();
    t_sbox();
    t_undef();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule